// File: doc/BRIEF.md
# Interrupt Vector Placement Controller

This block sits beside a small microcontroller core and decides where the interrupt vector table lives in program memory. The table sits either at word address 0 or at the first word of a boot-loader region at the top of memory. The block holds a one-byte control register on a single-cycle write/read port. Besides the placement bit, that register holds five interrupt enable bits. From the register and the boot-region size code, the block produces the table base and the fetch address of any vector slot.

The placement bit is guarded. Software first arms a change flag. It then has a short window of cycles in which to write the new placement. From the moment the flag arms, the block tells the core to refuse interrupts. That refusal ends when the window lapses unused, or when the core retires the instruction after the placement write. The refusal is a separate gating output. It never alters the core's own global interrupt-enable flag. A second gate blocks interrupts while code runs in a region that is locked against the region holding the vectors.

Top module: `ivec_relocator`

## Requirements
- R1: After reset, the register reads 0x00, the placement bit is 0, the change flag is clear, `irq_suppress` is 0 and `vec_base` is 0.
- R2: Register layout: bit 0 is the change flag, bit 1 is the placement bit, bit 2 is reserved and always reads 0, and bits 7..3 are the enables that are output on `irq_enable[4:0]`. A write always updates the enables.
- R3: A write with bit 0 = 1 sets the change flag and opens a window of WIN_CYC (4) cycles. A write with bit 0 = 0 that lands in the 1st to 4th cycle after the arming write loads bit 1 into the placement bit and clears the change flag.
- R4: A placement write made while the change flag is clear, including the 5th cycle after arming, leaves the placement bit unchanged.
- R5: If no placement write arrives, the change flag clears by itself after WIN_CYC cycles, and suppression ends with it.
- R6: `irq_suppress` is 1 in every cycle that the change flag reads 1.
- R7: After an accepted placement write, `irq_suppress` stays 1 until the first `retire` pulse seen in a later cycle, and is 0 from the next cycle. A `retire` pulse in the same cycle as the placement write does not end it.
- R8: With placement 0, `vec_base` is 0. With placement 1, `vec_base` is 2^ADDR_W − (128 << `boot_size`) words. For ADDR_W = 13, codes 0..3 give 0x1F80, 0x1F00, 0x1E00 and 0x1C00.
- R9: `vec_addr` = `vec_base` + 2·`irq_index`. For code 3 with placement 1, index 0 gives 0x1C00, index 1 gives 0x1C02 and index 27 gives 0x1C36.
- R10: `irq_allow` is 0 when suppression is active. It is also 0 when placement is 1, `lock_app` is set and `exec_in_boot` = 0. It is also 0 when placement is 0, `lock_boot` is set and `exec_in_boot` = 1. In all other cases it is 1.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| bus_wr | input | 1 | Register write strobe, one cycle |
| bus_wdata | input | 8 | Register write data |
| bus_rdata | output | 8 | Register read value |
| boot_size | input | 2 | Boot region size code: 128 << code words |
| lock_app | input | 1 | Application region lock flag |
| lock_boot | input | 1 | Boot region lock flag |
| exec_in_boot | input | 1 | Core is executing from the boot region |
| retire | input | 1 | Instruction retire strobe from the core |
| irq_index | input | 5 | Interrupt slot number |
| vec_base | output | 13 | Selected vector table base (word address) |
| vec_addr | output | 13 | Fetch address of slot `irq_index` |
| irq_enable | output | 5 | Interrupt enable bits from register bits 7..3 |
| irq_suppress | output | 1 | Timed interrupt suppression active |
| irq_allow | output | 1 | Interrupt acceptance permitted |

## Verification
The hardest situations to reach are the two edges of the timed window. One is a placement write in exactly the last open cycle. The other is a write one cycle later, which must be ignored. The stimulus arms the flag with one write, then counts a fixed number of idle clocks before the second write. It also places `retire` pulses inside the window and in the same cycle as the placement write. This shows that only a later retire releases suppression.

// File: rtl/ivr_pkg.sv
package ivr_pkg;
  localparam int ADDR_W  = 13;
  localparam int IDX_W   = 5;
  localparam int EN_W    = 5;
  localparam int WIN_CYC = 4;
  localparam int MIN_BOOT = 128;

  // First word of the boot region for a given size code.
  function automatic logic [ADDR_W-1:0] boot_start(input logic [1:0] code);
    logic [ADDR_W:0] top;
    logic [ADDR_W:0] span;
    top  = (ADDR_W+1)'(1) << ADDR_W;
    span = (ADDR_W+1)'(MIN_BOOT) << code;
    return ADDR_W'(top - span);
  endfunction

  // Each slot takes two program words.
  function automatic logic [ADDR_W-1:0] slot_addr(input logic [ADDR_W-1:0] base,
                                                  input logic [IDX_W-1:0] idx);
    return base + (ADDR_W'(idx) << 1);
  endfunction
endpackage

// File: rtl/ivr_unlock.sv
module ivr_unlock
  import ivr_pkg::*;
#(
  parameter int WIN = WIN_CYC
) (
  input  logic clk,
  input  logic rst_n,
  input  logic wr,
  input  logic arm_bit,
  input  logic sel_bit,
  input  logic retire,
  output logic ce_q,
  output logic sel_q,
  output logic suppress
);
  localparam int CNT_W = $clog2(WIN + 1);

  logic [CNT_W-1:0] cnt_q;
  logic hold_q;
  logic arm_ev, sel_ev, lapse_ev;

  assign arm_ev   = wr && arm_bit;
  assign sel_ev   = wr && !arm_bit && ce_q;
  assign lapse_ev = ce_q && !wr && (cnt_q == CNT_W'(1));

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      ce_q  <= 1'b0;
      sel_q <= 1'b0;
      cnt_q <= '0;
    end else if (arm_ev) begin
      ce_q  <= 1'b1;
      cnt_q <= CNT_W'(WIN);
    end else if (sel_ev) begin
      ce_q  <= 1'b0;
      sel_q <= sel_bit;
      cnt_q <= '0;
    end else if (ce_q) begin
      if (cnt_q == CNT_W'(1)) ce_q <= 1'b0;
      cnt_q <= cnt_q - CNT_W'(1);
    end
  end

  always_ff @(posedge clk) begin
    if (!rst_n)      hold_q <= 1'b0;
    else if (sel_ev) hold_q <= 1'b1;
    else if (retire) hold_q <= 1'b0;
  end

  assign suppress = ce_q || hold_q;

  // Checker: length of the open window.
  logic [CNT_W:0] open_len;
  always_ff @(posedge clk) begin
    if (!rst_n)        open_len <= '0;
    else if (arm_ev)   open_len <= '0;
    else if (ce_q)     open_len <= open_len + 1'b1;
    else               open_len <= '0;
  end

  assert_window_bound_R5: assert property (@(posedge clk) disable iff (!rst_n)
    open_len <= (CNT_W+1)'(WIN));
  assert_lapse_closes_R5: assert property (@(posedge clk) disable iff (!rst_n)
    lapse_ev |=> !ce_q);
  assert_sel_locked_R4: assert property (@(posedge clk) disable iff (!rst_n)
    !ce_q |=> $stable(sel_q));
  assert_suppress_open_R6: assert property (@(posedge clk) disable iff (!rst_n)
    ce_q |-> suppress);
  assert_hold_release_R7: assert property (@(posedge clk) disable iff (!rst_n)
    (hold_q && retire && !sel_ev && !arm_ev) |=> !suppress);
  assert_hold_after_sel_R7: assert property (@(posedge clk) disable iff (!rst_n)
    sel_ev |=> suppress);
endmodule

// File: rtl/ivr_vecgen.sv
module ivr_vecgen
  import ivr_pkg::*;
(
  input  logic              clk,
  input  logic              rst_n,
  input  logic              sel,
  input  logic [1:0]        size_code,
  input  logic [IDX_W-1:0]  idx,
  output logic [ADDR_W-1:0] base,
  output logic [ADDR_W-1:0] addr
);
  assign base = sel ? boot_start(size_code) : '0;
  assign addr = slot_addr(base, idx);

  assert_app_base_R8: assert property (@(posedge clk) disable iff (!rst_n)
    !sel |-> (base == '0));
  assert_slot_even_R9: assert property (@(posedge clk) disable iff (!rst_n)
    addr[0] == base[0]);
endmodule

// File: rtl/ivr_gate.sv
module ivr_gate (
  input  logic clk,
  input  logic rst_n,
  input  logic sel,
  input  logic suppress,
  input  logic lock_app,
  input  logic lock_boot,
  input  logic in_boot,
  output logic allow
);
  logic region_block;

  assign region_block = (sel && lock_app && !in_boot) ||
                        (!sel && lock_boot && in_boot);
  assign allow = !suppress && !region_block;

  assert_suppress_gates_R10: assert property (@(posedge clk) disable iff (!rst_n)
    suppress |-> !allow);
  assert_free_allows_R10: assert property (@(posedge clk) disable iff (!rst_n)
    (!suppress && !lock_app && !lock_boot) |-> allow);
endmodule

// File: rtl/ivec_relocator.sv
module ivec_relocator
  import ivr_pkg::*;
(
  input  logic              clk,
  input  logic              rst_n,
  input  logic              bus_wr,
  input  logic [7:0]        bus_wdata,
  output logic [7:0]        bus_rdata,
  input  logic [1:0]        boot_size,
  input  logic              lock_app,
  input  logic              lock_boot,
  input  logic              exec_in_boot,
  input  logic              retire,
  input  logic [IDX_W-1:0]  irq_index,
  output logic [ADDR_W-1:0] vec_base,
  output logic [ADDR_W-1:0] vec_addr,
  output logic [EN_W-1:0]   irq_enable,
  output logic              irq_suppress,
  output logic              irq_allow
);
  logic ce_q, sel_q;
  logic [EN_W-1:0] en_q;

  always_ff @(posedge clk) begin
    if (!rst_n)      en_q <= '0;
    else if (bus_wr) en_q <= bus_wdata[7:3];
  end

  ivr_unlock #(.WIN(WIN_CYC)) u_unlock (
    .clk(clk), .rst_n(rst_n), .wr(bus_wr), .arm_bit(bus_wdata[0]),
    .sel_bit(bus_wdata[1]), .retire(retire),
    .ce_q(ce_q), .sel_q(sel_q), .suppress(irq_suppress)
  );

  ivr_vecgen u_vec (
    .clk(clk), .rst_n(rst_n), .sel(sel_q), .size_code(boot_size),
    .idx(irq_index), .base(vec_base), .addr(vec_addr)
  );

  ivr_gate u_gate (
    .clk(clk), .rst_n(rst_n), .sel(sel_q), .suppress(irq_suppress),
    .lock_app(lock_app), .lock_boot(lock_boot), .in_boot(exec_in_boot),
    .allow(irq_allow)
  );

  assign irq_enable = en_q;
  assign bus_rdata  = {en_q, 1'b0, sel_q, ce_q};

  assert_reserved_zero_R2: assert property (@(posedge clk) disable iff (!rst_n)
    bus_rdata[2] == 1'b0);
  assert_enable_write_R2: assert property (@(posedge clk) disable iff (!rst_n)
    bus_wr |=> (irq_enable == $past(bus_wdata[7:3])));
endmodule

// File: tb/sim_ivec_relocator.sv
module sim_ivec_relocator;
  logic clk = 0, rst_n = 0;
  logic bus_wr = 0;
  logic [7:0] bus_wdata = 0;
  logic [7:0] bus_rdata;
  logic [1:0] boot_size = 2'd3;
  logic lock_app = 0, lock_boot = 0, exec_in_boot = 0, retire = 0;
  logic [4:0] irq_index = 0;
  logic [12:0] vec_base, vec_addr;
  logic [4:0] irq_enable;
  logic irq_suppress, irq_allow;
  int total = 0, bad = 0;

  always #2 clk = ~clk;

  ivec_relocator u0 (.*);

  task automatic chk(string tag, int act, int exp);
    total++;
    if (act !== exp) begin
      bad++;
      $display("FAIL %s actual=0x%0h expected=0x%0h", tag, act, exp);
    end
  endtask

  // Inputs change at negedge; one posedge later results are sampled at next negedge.
  task automatic wr(input logic [7:0] d, input logic ret = 0);
    bus_wr = 1; bus_wdata = d; retire = ret;
    @(negedge clk);
    bus_wr = 0; retire = 0;
  endtask

  task automatic idle(input int n);
    repeat (n) @(negedge clk);
  endtask

  function automatic int exp_base(input int code);
    return 8192 - 128 * (1 << code);
  endfunction

  task automatic t_reset;
    chk("R1 rdata", bus_rdata, 0);
    chk("R1 base", vec_base, 0);
    chk("R1 suppress", irq_suppress, 0);
    chk("R1 allow", irq_allow, 1);
  endtask

  task automatic t_unguarded;
    wr(8'h02);
    chk("R4 sel ignored", bus_rdata, 8'h00);
    chk("R4 base", vec_base, 0);
  endtask

  task automatic t_fast_switch;
    wr(8'h01);
    chk("R3 armed", bus_rdata, 8'h01);
    chk("R6 suppress", irq_suppress, 1);
    chk("R10 allow off", irq_allow, 0);
    wr(8'h02, 1'b1);  // retire in same cycle as select write
    chk("R3 sel set", bus_rdata, 8'h02);
    chk("R7 hold", irq_suppress, 1);
    idle(2);
    chk("R7 hold idle", irq_suppress, 1);
    retire = 1; @(negedge clk); retire = 0;
    chk("R7 released", irq_suppress, 0);
    chk("R8 base 1K", vec_base, 16'h1C00);
    irq_index = 0;  #0; chk("R9 idx0", vec_addr, 16'h1C00);
    irq_index = 1;  #1; chk("R9 idx1", vec_addr, 16'h1C02);
    irq_index = 27; #1; chk("R9 idx27", vec_addr, 16'h1C36);
  endtask

  task automatic t_last_slot;
    wr(8'h01);
    retire = 1; @(negedge clk); retire = 0;  // retire during window
    chk("R6 retire in window", irq_suppress, 1);
    idle(2);
    wr(8'h00);  // 4th cycle after arming
    chk("R3 late-in-window accepted", bus_rdata, 8'h00);
    chk("R8 base back to 0", vec_base, 0);
    retire = 1; @(negedge clk); retire = 0;
    chk("R7 released2", irq_suppress, 0);
  endtask

  task automatic t_expired;
    wr(8'h01);
    idle(3);
    chk("R6 still open", irq_suppress, 1);
    idle(1);
    chk("R5 flag cleared", bus_rdata, 8'h00);
    chk("R5 suppress ended", irq_suppress, 0);
    wr(8'h02);
    chk("R4 5th cycle ignored", bus_rdata, 8'h00);
  endtask

  task automatic t_sizes;
    wr(8'h01); wr(8'h02); retire = 1; @(negedge clk); retire = 0;
    irq_index = 3;
    for (int c = 0; c < 4; c++) begin
      boot_size = 2'(c); #1;
      chk("R8 size", vec_base, exp_base(c));
      chk("R9 size addr", vec_addr, exp_base(c) + 6);
    end
    boot_size = 2'd3;
  endtask

  task automatic t_locks;
    // placement 1 here
    lock_app = 1; exec_in_boot = 0; #1;
    chk("R10 app lock blocks", irq_allow, 0);
    exec_in_boot = 1; #1;
    chk("R10 app lock in boot ok", irq_allow, 1);
    lock_app = 0; lock_boot = 1; #1;
    chk("R10 boot lock ignored sel1", irq_allow, 1);
    @(negedge clk);
    wr(8'h01); wr(8'h00); retire = 1; @(negedge clk); retire = 0;
    chk("R10 boot lock sel0 in boot", irq_allow, 0);
    exec_in_boot = 0; #1;
    chk("R10 boot lock sel0 in app", irq_allow, 1);
    lock_boot = 0;
    @(negedge clk);
  endtask

  task automatic t_enables;
    wr(8'hFC);
    chk("R2 reserved and enables", bus_rdata, 8'hF8);
    chk("R2 enable out", irq_enable, 5'h1F);
    wr(8'h51);
    chk("R2 arm keeps enables", bus_rdata, 8'h51);
    wr(8'h52);
    chk("R2 sel with enables", bus_rdata, 8'h52);
    retire = 1; @(negedge clk); retire = 0;
  endtask

  initial begin
    fork
      begin
        idle(3);
        @(negedge clk) rst_n = 1;
        t_reset();
        t_unguarded();
        t_fast_switch();
        t_last_slot();
        t_expired();
        t_sizes();
        t_locks();
        t_enables();
      end
      begin
        repeat (5000) @(posedge clk);
        total++; bad++;
        $display("FAIL watchdog actual=hung expected=done");
      end
    join_any
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end
endmodule